// File: doc/BRIEF.md
# NAND Ready-Edge Interrupt Unit

This unit watches the ready/busy line of a NAND flash device and raises an interrupt when a long operation, such as a block erase or a page program, finishes. The raw pin goes through a parameterised synchronizer and an edge detector. A busy-to-ready transition latches a ready-request event bit. The host programs a mask with a global enable bit, waits for the interrupt, then clears the event by writing ones to it. Any timeout handling stays with the host.

The host reaches three byte-wide registers through a simple write strobe and a combinational read port. A level register shows the live busy state. An event register holds write-one-to-clear event bits; bit 0 is the ready request, and bits 3:1 are reserved for other sources and never set. A mask register holds per-source enables plus a global enable.

Top module: `nand_rdy_irq`

## Requirements
- R1: After reset the event register (address 1) and the mask register (address 2) read 0x00, the level register (address 0) reads 0x00, and `irq_o` is low. The reset value assumes the device is ready.
- R2: Bit 7 of the level register (address 0) reads 1 while the synchronized ready/busy line is low (busy) and 0 while it is high. Its other bits read 0. The interrupt state does not affect it.
- R3: A low-to-high transition of the synchronized ready/busy line sets event bit 0.
- R4: A high-to-low transition (ready to busy), or a steady level, does not set any event bit.
- R5: Writing to address 1 clears each event bit whose written data bit is 1 and leaves the bits written with 0 unchanged. Writing 0x0F clears all event bits.
- R6: Reading any register changes no state. The event bits hold their value until they are cleared by a write or set by an edge.
- R7: `irq_o` is high exactly when mask bit 7 (global enable) is 1 and some event bit n in 3:0 is set while mask bit n is set. Writing 0x81 to address 2 enables the ready-request interrupt.
- R8: `irq_o` stays low when mask bit 7 is 0, even with mask bit 0 and event bit 0 both set. Writing 0x00 to address 2 disables every source. Address 2 reads back the last byte written to it.
- R9: If an edge sets event bit 0 in the same cycle that a write to address 1 clears it, the bit ends up set.
- R10: A change on `rb_raw` that is sampled at clock edge k appears in the level register after edge k+SYNC_STAGES-1. A rising change raises the event bit and `irq_o` after edge k+SYNC_STAGES.
- R11: Event bits 3:1 and register bits 7:4 of address 1 always read 0. Address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rb_raw | input | 1 | Raw NAND ready/busy pin, high means ready |
| reg_addr | input | 2 | Register select: 0 level, 1 event, 2 mask, 3 reserved |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The bound checker checks on every cycle that:
- a detected rising edge sets event bit 0, and event bit 0 never rises without one;
- the event bits stay still without a write or an edge, and a clearing write clears them when no edge collides;
- the interrupt never goes high without the global enable;
- the busy read-back follows the synchronized line, and the reserved event bits stay zero.

The exact latency through the synchronizer, the set-over-clear priority with the write landing on the edge cycle, and mask settings 0x01, 0x80, 0x81 and 0x00 can only be shown by the bench's timed scenarios. There, a behavioural model is compared with the read port and the interrupt on every clock.

// File: rtl/nri_pkg.sv
`timescale 1ns/1ps
package nri_pkg;
   localparam int unsigned NRI_AW    = 2;
   localparam int unsigned NRI_DW    = 8;
   localparam int unsigned BUSY_BIT  = 7;
   localparam int unsigned GEN_BIT   = 7;
   localparam int unsigned RDY_SRC   = 0;

   typedef enum logic [NRI_AW-1:0] {
      REG_LEVEL = 2'd0,
      REG_EVT   = 2'd1,
      REG_MASK  = 2'd2,
      REG_RSVD  = 2'd3
   } nri_reg_e;
endpackage

// File: rtl/nri_sync.sv
`timescale 1ns/1ps
module nri_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/nri_edge.sv
`timescale 1ns/1ps
module nri_edge #(
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic rise
);
   logic prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= RST_VAL;
      else        prev <= lvl;
   end

   assign rise = lvl & ~prev;
endmodule

// File: rtl/nri_regs.sv
`timescale 1ns/1ps
module nri_regs
   import nri_pkg::*;
#(
   parameter int unsigned NSRC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   set_evt,
   input  logic              evt_wr,
   input  logic              mask_wr,
   input  logic [NRI_DW-1:0] wdata,
   output logic [NSRC-1:0]   evt_q,
   output logic [NRI_DW-1:0] mask_q,
   output logic              irq
);
   logic [NSRC-1:0] clr_vec;
   logic [NSRC-1:0] evt_d;

   always_comb begin
      clr_vec = evt_wr ? wdata[NSRC-1:0] : '0;
      evt_d   = (evt_q & ~clr_vec) | set_evt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_q  <= '0;
         mask_q <= '0;
      end else begin
         evt_q <= evt_d;
         if (mask_wr) mask_q <= wdata;
      end
   end

   assign irq = mask_q[GEN_BIT] & (|(evt_q & mask_q[NSRC-1:0]));
endmodule

// File: rtl/nand_rdy_irq.sv
`timescale 1ns/1ps
module nand_rdy_irq
   import nri_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned NSRC        = 4,
   parameter bit          RDY_RST     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rb_raw,
   input  logic [NRI_AW-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [NRI_DW-1:0] reg_wdata,
   output logic [NRI_DW-1:0] reg_rdata,
   output logic              irq_o
);
   localparam int unsigned PAD_W = NRI_DW - NSRC;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("nand_rdy_irq: SYNC_STAGES must be at least 2");
   end
   if (NSRC < 1 || NSRC > GEN_BIT) begin : g_bad_nsrc
      $error("nand_rdy_irq: NSRC must lie in 1..7");
   end

   logic            rb_sync;
   logic            rise;
   logic [NSRC-1:0] set_evt;
   logic [NSRC-1:0] evt_q;
   logic [NRI_DW-1:0] mask_q;
   logic            evt_wr;
   logic            mask_wr;

   nri_sync #(.STAGES(SYNC_STAGES), .RST_VAL(RDY_RST)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(rb_raw), .q(rb_sync)
   );

   nri_edge #(.RST_VAL(RDY_RST)) u_edge (
      .clk(clk), .rst_n(rst_n), .lvl(rb_sync), .rise(rise)
   );

   if (NSRC > 1) begin : g_spare
      assign set_evt = {{(NSRC-1){1'b0}}, rise};
   end else begin : g_single
      assign set_evt = rise;
   end

   assign evt_wr  = reg_wr && (reg_addr == REG_EVT);
   assign mask_wr = reg_wr && (reg_addr == REG_MASK);

   nri_regs #(.NSRC(NSRC)) u_regs (
      .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .evt_wr(evt_wr),
      .mask_wr(mask_wr), .wdata(reg_wdata), .evt_q(evt_q),
      .mask_q(mask_q), .irq(irq_o)
   );

   always_comb begin
      unique case (reg_addr)
         REG_LEVEL: reg_rdata = {~rb_sync, {BUSY_BIT{1'b0}}};
         REG_EVT:   reg_rdata = {{PAD_W{1'b0}}, evt_q};
         REG_MASK:  reg_rdata = mask_q;
         default:   reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/nri_checker.sv
`timescale 1ns/1ps
module nri_checker #(
   parameter int unsigned NSRC = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            rise,
   input logic            rb_sync,
   input logic [NSRC-1:0] evt_q,
   input logic [7:0]      mask_q,
   input logic            irq_o,
   input logic            reg_wr,
   input logic [1:0]      reg_addr,
   input logic [7:0]      reg_wdata,
   input logic [7:0]      reg_rdata
);
   logic evt_write;
   assign evt_write = reg_wr && (reg_addr == 2'd1);

   assert_edge_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> evt_q[0]);

   assert_no_spurious_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!rise && !evt_q[0]) |=> !evt_q[0]);

   assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_write && reg_wdata[0] && !rise) |=> !evt_q[0]);

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt_write && !rise) |=> $stable(evt_q));

   assert_global_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> mask_q[7]);

   assert_busy_view_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == 2'd0) |-> (reg_rdata == {~rb_sync, 7'b0}));

   if (NSRC > 1) begin : g_spare_chk
      assert_spare_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
         evt_q[NSRC-1:1] == '0);
   end
endmodule

bind nand_rdy_irq nri_checker #(.NSRC(NSRC)) u_chk (
   .clk(clk), .rst_n(rst_n), .rise(rise), .rb_sync(rb_sync), .evt_q(evt_q),
   .mask_q(mask_q), .irq_o(irq_o), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
);

// File: tb/tb_nand_rdy_irq.sv
`timescale 1ns/1ps
module tb_nand_rdy_irq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rb_raw = 1'b1;
   logic [1:0] reg_addr = 2'd0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       irq_o;

   int    total = 0;
   int    bad = 0;
   bit    run_cmp = 1'b0;
   string cur_req = "R1";

   always #5 clk = ~clk;

   nand_rdy_irq dut (
      .clk(clk), .rst_n(rst_n), .rb_raw(rb_raw), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_o(irq_o)
   );

   // behavioural model: a queue of raw samples, newest first
   bit       mq[$] = '{1'b1, 1'b1, 1'b1};
   bit [3:0] m_st = 4'h0;
   bit [7:0] m_mask = 8'h00;

   always @(posedge clk) begin
      if (!rst_n) begin
         mq = '{1'b1, 1'b1, 1'b1};
         m_st = 4'h0;
         m_mask = 8'h00;
      end else begin
         bit       edge_seen;
         bit [3:0] clr;
         edge_seen = mq[1] && !mq[2];
         clr = (reg_wr && reg_addr == 2'd1) ? reg_wdata[3:0] : 4'h0;
         m_st = (m_st & ~clr) | {3'b000, edge_seen};
         if (reg_wr && reg_addr == 2'd2) m_mask = reg_wdata;
         mq.push_front(rb_raw);
         void'(mq.pop_back());
      end
   end

   function automatic bit [7:0] model_rd(input bit [1:0] a);
      case (a)
         2'd0:    return {~mq[1], 7'b0};
         2'd1:    return {4'h0, m_st};
         2'd2:    return m_mask;
         default: return 8'h00;
      endcase
   endfunction

   function automatic bit model_irq();
      return m_mask[7] && ((m_st & m_mask[3:0]) != 4'h0);
   endfunction

   task automatic chk(input string tag, input int got, input int exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (run_cmp && rst_n) begin
         chk({cur_req, " cycle rdata"}, reg_rdata, model_rd(reg_addr));
         chk({cur_req, " cycle irq"}, irq_o, model_irq());
      end
   end

   task automatic wr(input bit [1:0] a, input bit [7:0] d);
      @(posedge clk); #2;
      reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
      @(posedge clk); #2;
      reg_wr = 1'b0;
   endtask

   task automatic set_raw(input bit v);
      @(posedge clk); #2;
      rb_raw = v;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic expect_rd(input string tag, input bit [1:0] a, input bit [7:0] e);
      reg_addr = a;
      @(negedge clk);
      chk(tag, reg_rdata, e);
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #2_000_000;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      run_cmp = 1'b1;

      cur_req = "R1";
      expect_rd("R1 event reset", 2'd1, 8'h00);
      expect_rd("R1 mask reset", 2'd2, 8'h00);
      expect_rd("R1 level reset", 2'd0, 8'h00);
      chk("R1 irq reset", irq_o, 0);

      // ready -> busy: level shows busy, no event (R2, R4)
      cur_req = "R2";
      set_raw(1'b0);
      idle(4);
      expect_rd("R2 busy visible", 2'd0, 8'h80);
      cur_req = "R4";
      expect_rd("R4 falling edge sets nothing", 2'd1, 8'h00);

      // busy -> ready: event bit 0 set (R3), read does not clear (R6)
      cur_req = "R3";
      set_raw(1'b1);
      idle(4);
      expect_rd("R3 rise sets event", 2'd1, 8'h01);
      expect_rd("R2 ready visible", 2'd0, 8'h00);
      cur_req = "R6";
      idle(3);
      expect_rd("R6 read keeps event", 2'd1, 8'h01);

      // global enable gating (R8) and enable (R7)
      cur_req = "R8";
      wr(2'd2, 8'h01);
      @(negedge clk); chk("R8 no global enable", irq_o, 0);
      wr(2'd2, 8'h80);
      @(negedge clk); chk("R8 global only", irq_o, 0);
      cur_req = "R7";
      wr(2'd2, 8'h81);
      @(negedge clk); chk("R7 enabled irq", irq_o, 1);
      expect_rd("R8 mask readback", 2'd2, 8'h81);
      cur_req = "R8";
      wr(2'd2, 8'h00);
      @(negedge clk); chk("R8 disable all", irq_o, 0);
      expect_rd("R8 event kept while masked", 2'd1, 8'h01);

      // write-one-to-clear (R5), spare bits (R11)
      cur_req = "R5";
      wr(2'd2, 8'h81);
      wr(2'd1, 8'h0E);
      expect_rd("R5 zero bit untouched", 2'd1, 8'h01);
      wr(2'd1, 8'h0F);
      expect_rd("R5 all cleared", 2'd1, 8'h00);
      chk("R5 irq dropped", irq_o, 0);
      cur_req = "R11";
      wr(2'd1, 8'hFF);
      expect_rd("R11 spare bits zero", 2'd1, 8'h00);
      expect_rd("R11 reserved address", 2'd3, 8'h00);

      // latency through synchronizer (R10)
      cur_req = "R10";
      set_raw(1'b0);
      idle(4);
      reg_addr = 2'd0;
      set_raw(1'b1);               // sampled at next edge k
      @(negedge clk); chk("R10 before k", reg_rdata, 8'h80);
      @(negedge clk); chk("R10 after k", reg_rdata, 8'h80);
      @(negedge clk); chk("R10 after k+1 level", reg_rdata, 8'h00);
      chk("R10 after k+1 irq", irq_o, 0);
      @(negedge clk); chk("R10 after k+2 irq", irq_o, 1);
      wr(2'd1, 8'h01);
      expect_rd("R10 cleared", 2'd1, 8'h00);

      // set wins over clear in the same cycle (R9)
      cur_req = "R9";
      set_raw(1'b0);
      idle(4);
      set_raw(1'b1);               // sampled at P1; event set at P3
      idle(1);
      wr(2'd1, 8'h01);             // write sampled at P3
      expect_rd("R9 set beats clear", 2'd1, 8'h01);
      chk("R9 irq", irq_o, 1);
      wr(2'd1, 8'h0F);
      expect_rd("R9 later clear", 2'd1, 8'h00);

      // steady level creates no event (R4)
      cur_req = "R4";
      idle(6);
      expect_rd("R4 steady ready", 2'd1, 8'h00);

      run_cmp = 1'b0;
      finish_run();
   end
endmodule